// File: doc/BRIEF.md
# Serial Channel Modem Handshake Controller

This block produces and interprets the handshake lines of one serial channel. It drives an active-low request-to-send line. Outside bus configuration, software controls that line, and the line is released only once the transmitter has gone quiet. In bus configuration, the line instead follows the transmitted frame (one clock late, with collision bits masked), follows the received frame, or stays high.

The active-low clear-to-send line gates the transmitter. The carrier-detect line is read according to the channel's clock mode. In most modes it is a plain modem input, and with auto-start it serves as the receiver enable. In one mode it is a receive strobe, and in another it is a frame synchronization mark. Both inputs pass through a synchronizer. Each one raises its own sticky, maskable change flag.

Top module: `modem_ctl`

## Requirements
- R1: Outside bus configuration (`cfg_bus_en`=0), `cfg_rts_req`=1 drives `rts_n` low on the next clock edge.
- R2: Outside bus configuration, once `rts_n` is low and `cfg_rts_req` is cleared, `rts_n` stays low while `tx_busy` or `tx_pend` is 1. It goes high on the first edge at which both are 0.
- R3: In bus configuration with `cfg_bus_rts` = 0, `rts_n` is low exactly when `tx_frame` was 1 and `tx_coll` was 0 two edges earlier. This is the frame delayed by one extra clock, with collision bits held high.
- R4: In bus configuration with `cfg_bus_rts` = 1, `rts_n` is the inverse of `rx_frame` one edge later.
- R5: In bus configuration with `cfg_bus_rts` = 2 or 3, `rts_n` stays high. `cfg_rts_req` and the frame flags have no effect on it.
- R6: `cts_lvl` shows the synchronized `cts_n` two edges after a change. `tx_en` equals its inverse one edge after that, so the transmitter is enabled only while `cts_n` is low.
- R7: A level change on `cts_n` sets `cts_irq` three edges after the change when `cfg_cts_ie`=1. With `cfg_cts_ie`=0 the flag stays 0.
- R8: In clock modes 0, 2, 3, 4, 6 and 7, `rx_en` is 1 when `cfg_autostart`=0. When `cfg_autostart`=1 it follows the synchronized `cd_in`, three edges after a change. `cd_lvl` shows the synchronized level after two edges.
- R9: In clock mode 1, `rx_strobe` follows the synchronized `cd_in` and `frame_sync` is 0. In clock mode 5, `frame_sync` follows it and `rx_strobe` is 0. In both modes `rx_en` is 1.
- R10: A level change on `cd_in` sets `cd_irq` three edges after the change when `cfg_cd_ie`=1. With `cfg_cd_ie`=0 the flag stays 0.
- R11: Each flag stays set until a one-cycle clear pulse (`irq_clr_cts` or `irq_clr_cd`), which clears it on the next edge. If a change arrives in the same cycle as a clear, the flag stays set.
- R12: Synchronous reset (`rst`=1) gives `rts_n`=1, `tx_en`=0, `rx_en`=0, `rx_strobe`=0, `frame_sync`=0 and both flags 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rts_req | input | 1 | Software request-to-send bit |
| cfg_bus_en | input | 1 | Bus configuration enable |
| cfg_bus_rts | input | 2 | Bus RTS mode: 0 transmit track, 1 receive track, 2/3 off |
| cfg_autostart | input | 1 | Carrier-detect acts as receiver enable |
| cfg_clk_mode | input | 3 | Channel clock mode 0..7 |
| cfg_cts_ie | input | 1 | CTS change flag enable |
| cfg_cd_ie | input | 1 | Carrier-detect change flag enable |
| tx_busy | input | 1 | Transmitter still shifting |
| tx_pend | input | 1 | Further transmit request pending |
| tx_frame | input | 1 | Transmit frame in progress |
| tx_coll | input | 1 | Current transmit bit is a collision bit |
| rx_frame | input | 1 | Receive frame in progress |
| cts_n | input | 1 | Clear-to-send, active low, asynchronous |
| cd_in | input | 1 | Carrier-detect, asynchronous |
| irq_clr_cts | input | 1 | Clear pulse for `cts_irq` |
| irq_clr_cd | input | 1 | Clear pulse for `cd_irq` |
| rts_n | output | 1 | Request-to-send, active low |
| tx_en | output | 1 | Transmitter enable |
| rx_en | output | 1 | Receiver enable |
| rx_strobe | output | 1 | Receive strobe qualifier (mode 1) |
| frame_sync | output | 1 | Frame synchronization qualifier (mode 5) |
| cts_lvl | output | 1 | Synchronized `cts_n` level |
| cd_lvl | output | 1 | Synchronized `cd_in` level |
| cts_irq | output | 1 | Sticky CTS change flag |
| cd_irq | output | 1 | Sticky carrier-detect change flag |

## Verification
Results fall due at different delays. A configuration or software RTS change shows one edge later, and a bus transmit-track change shows two edges later. A pin change reaches the synchronized level after two edges, and reaches the gated outputs and the change flags after three. The bench drives every input on the falling clock edge and then steps a counted number of edges before each sample. Where it matters, it also samples one edge early, so that an output which moves too soon fails its check. The clear-versus-set collision is lined up by placing the clear pulse in the exact cycle in which the detected change is present.

// File: rtl/modem_pkg.sv
package modem_pkg;
  localparam int CLK_MODE_W = 3;
  localparam logic [CLK_MODE_W-1:0] CM_STROBE = 3'd1;
  localparam logic [CLK_MODE_W-1:0] CM_FSYNC  = 3'd5;

  typedef enum logic [1:0] {
    BUS_RTS_TX   = 2'd0,
    BUS_RTS_RX   = 2'd1,
    BUS_RTS_OFF  = 2'd2,
    BUS_RTS_OFF3 = 2'd3
  } bus_rts_e;

  localparam int N_PINS  = 2;
  localparam int PIN_CTS = 0;
  localparam int PIN_CD  = 1;
  // idle (reset) level of each synchronized pin
  localparam logic [N_PINS-1:0] PIN_IDLE = 2'b01;
endpackage

// File: rtl/mdm_sync_edge.sv
module mdm_sync_edge #(
  parameter int N      = 2,
  parameter int STAGES = 2,
  parameter logic [N-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] level,
  output logic [N-1:0] chg
);
  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_pin
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk) begin
      if (rst) chain_q <= {STAGES{IDLE[i]}};
      else     chain_q <= {chain_q[STAGES-2:0], din[i]};
    end
    assign level[i] = chain_q[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= IDLE;
    else     prev_q <= level;
  end

  assign chg = level ^ prev_q;
endmodule

// File: rtl/mdm_rts.sv
module mdm_rts
  import modem_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       rts_req,
  input  logic       bus_en,
  input  logic [1:0] bus_sel,
  input  logic       busy,
  input  logic       pend,
  input  logic       tx_frame,
  input  logic       tx_coll,
  input  logic       rx_frame,
  output logic       rts_n
);
  logic frame_d, coll_d, sw_low_q, sw_low_nx, rts_low_nx;
  bus_rts_e mode;

  assign mode = bus_rts_e'(bus_sel);

  // software path: hold low until transmitter drained
  assign sw_low_nx = rts_req | (sw_low_q & (busy | pend));

  always_comb begin
    if (!bus_en) rts_low_nx = sw_low_nx;
    else begin
      unique case (mode)
        BUS_RTS_TX: rts_low_nx = frame_d & ~coll_d;
        BUS_RTS_RX: rts_low_nx = rx_frame;
        default:    rts_low_nx = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_d  <= 1'b0;
      coll_d   <= 1'b0;
      sw_low_q <= 1'b0;
      rts_n    <= 1'b1;
    end else begin
      frame_d  <= tx_frame;
      coll_d   <= tx_coll;
      sw_low_q <= bus_en ? 1'b0 : sw_low_nx;
      rts_n    <= ~rts_low_nx;
    end
  end
endmodule

// File: rtl/mdm_qual.sv
module mdm_qual
  import modem_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cts_s,
  input  logic                  cd_s,
  input  logic                  autostart,
  input  logic [CLK_MODE_W-1:0] clk_mode,
  output logic                  tx_en,
  output logic                  rx_en,
  output logic                  rx_strobe,
  output logic                  frame_sync
);
  logic is_strobe, is_fsync;

  assign is_strobe = (clk_mode == CM_STROBE);
  assign is_fsync  = (clk_mode == CM_FSYNC);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_en      <= 1'b0;
      rx_en      <= 1'b0;
      rx_strobe  <= 1'b0;
      frame_sync <= 1'b0;
    end else begin
      tx_en      <= ~cts_s;
      rx_en      <= (is_strobe | is_fsync | ~autostart) ? 1'b1 : cd_s;
      rx_strobe  <= is_strobe & cd_s;
      frame_sync <= is_fsync & cd_s;
    end
  end
endmodule

// File: rtl/mdm_irq.sv
module mdm_irq #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] chg,
  input  logic [N-1:0] ie,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) flag[i] <= 1'b0;
      else     flag[i] <= (flag[i] & ~clr[i]) | (chg[i] & ie[i]);
    end
  end
endmodule

// File: rtl/modem_ctl.sv
module modem_ctl
  import modem_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_rts_req,
  input  logic       cfg_bus_en,
  input  logic [1:0] cfg_bus_rts,
  input  logic       cfg_autostart,
  input  logic [2:0] cfg_clk_mode,
  input  logic       cfg_cts_ie,
  input  logic       cfg_cd_ie,
  input  logic       tx_busy,
  input  logic       tx_pend,
  input  logic       tx_frame,
  input  logic       tx_coll,
  input  logic       rx_frame,
  input  logic       cts_n,
  input  logic       cd_in,
  input  logic       irq_clr_cts,
  input  logic       irq_clr_cd,
  output logic       rts_n,
  output logic       tx_en,
  output logic       rx_en,
  output logic       rx_strobe,
  output logic       frame_sync,
  output logic       cts_lvl,
  output logic       cd_lvl,
  output logic       cts_irq,
  output logic       cd_irq
);
  logic [N_PINS-1:0] pin_raw, pin_lvl, pin_chg, pin_ie, pin_clr, pin_flag;

  assign pin_raw[PIN_CTS] = cts_n;
  assign pin_raw[PIN_CD]  = cd_in;
  assign pin_ie[PIN_CTS]  = cfg_cts_ie;
  assign pin_ie[PIN_CD]   = cfg_cd_ie;
  assign pin_clr[PIN_CTS] = irq_clr_cts;
  assign pin_clr[PIN_CD]  = irq_clr_cd;

  mdm_sync_edge #(.N(N_PINS), .STAGES(SYNC_STAGES), .IDLE(PIN_IDLE)) u_sync (
    .clk(clk), .rst(rst), .din(pin_raw), .level(pin_lvl), .chg(pin_chg)
  );

  mdm_rts u_rts (
    .clk(clk), .rst(rst), .rts_req(cfg_rts_req), .bus_en(cfg_bus_en),
    .bus_sel(cfg_bus_rts), .busy(tx_busy), .pend(tx_pend),
    .tx_frame(tx_frame), .tx_coll(tx_coll), .rx_frame(rx_frame), .rts_n(rts_n)
  );

  mdm_qual u_qual (
    .clk(clk), .rst(rst), .cts_s(pin_lvl[PIN_CTS]), .cd_s(pin_lvl[PIN_CD]),
    .autostart(cfg_autostart), .clk_mode(cfg_clk_mode), .tx_en(tx_en),
    .rx_en(rx_en), .rx_strobe(rx_strobe), .frame_sync(frame_sync)
  );

  mdm_irq #(.N(N_PINS)) u_irq (
    .clk(clk), .rst(rst), .chg(pin_chg), .ie(pin_ie), .clr(pin_clr), .flag(pin_flag)
  );

  assign cts_lvl = pin_lvl[PIN_CTS];
  assign cd_lvl  = pin_lvl[PIN_CD];
  assign cts_irq = pin_flag[PIN_CTS];
  assign cd_irq  = pin_flag[PIN_CD];
endmodule

// File: rtl/modem_ctl_chk.sv
module modem_ctl_chk (
  input logic       clk,
  input logic       rst,
  input logic       cfg_rts_req,
  input logic       cfg_bus_en,
  input logic [1:0] cfg_bus_rts,
  input logic [2:0] cfg_clk_mode,
  input logic       cfg_cts_ie,
  input logic       tx_busy,
  input logic       tx_pend,
  input logic       rx_frame,
  input logic       irq_clr_cts,
  input logic       rts_n,
  input logic       tx_en,
  input logic       rx_strobe,
  input logic       cts_irq,
  input logic       cd_irq
);
  // R1
  sw_rts_low_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_rts_req && !cfg_bus_en) |=> !rts_n);
  // R2
  rts_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_bus_en && !rts_n && (tx_busy || tx_pend)) |=> !rts_n);
  // R4
  bus_rx_track_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_bus_en && cfg_bus_rts == 2'd1) |=> (rts_n == !$past(rx_frame)));
  // R5
  bus_off_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_bus_en && cfg_bus_rts[1]) |=> rts_n);
  // R7
  cts_flag_enable_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cts_irq) |-> $past(cfg_cts_ie));
  // R9
  strobe_mode_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_strobe) |-> ($past(cfg_clk_mode) == 3'd1));
  // R11
  cts_flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cts_irq) |-> $past(irq_clr_cts));
  // R12
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (rts_n && !tx_en && !cts_irq && !cd_irq));
endmodule

bind modem_ctl modem_ctl_chk u_chk (
  .clk(clk), .rst(rst), .cfg_rts_req(cfg_rts_req), .cfg_bus_en(cfg_bus_en),
  .cfg_bus_rts(cfg_bus_rts), .cfg_clk_mode(cfg_clk_mode), .cfg_cts_ie(cfg_cts_ie),
  .tx_busy(tx_busy), .tx_pend(tx_pend), .rx_frame(rx_frame),
  .irq_clr_cts(irq_clr_cts), .rts_n(rts_n), .tx_en(tx_en),
  .rx_strobe(rx_strobe), .cts_irq(cts_irq), .cd_irq(cd_irq)
);

// File: tb/sim_modem_ctl.sv
`timescale 1ns/1ps
module sim_modem_ctl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_rts_req = 0, cfg_bus_en = 0, cfg_autostart = 0;
  logic [1:0] cfg_bus_rts = 0;
  logic [2:0] cfg_clk_mode = 0;
  logic cfg_cts_ie = 0, cfg_cd_ie = 0;
  logic tx_busy = 0, tx_pend = 0, tx_frame = 0, tx_coll = 0, rx_frame = 0;
  logic cts_n = 1, cd_in = 0, irq_clr_cts = 0, irq_clr_cd = 0;
  logic rts_n, tx_en, rx_en, rx_strobe, frame_sync, cts_lvl, cd_lvl, cts_irq, cd_irq;
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  modem_ctl u0 (.*);

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic got, input logic exp, input string req, input string what);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic t_reset();
    tick(2);
    // R12: outputs inactive while reset is held
    chk(rts_n, 1, "R12", "rts_n");
    chk(tx_en, 0, "R12", "tx_en");
    chk(rx_en, 0, "R12", "rx_en");
    chk(rx_strobe, 0, "R12", "rx_strobe");
    chk(frame_sync, 0, "R12", "frame_sync");
    chk(cts_irq, 0, "R12", "cts_irq");
    chk(cd_irq, 0, "R12", "cd_irq");
    rst = 0;
    tick(1);
  endtask

  task automatic t_sw_rts();
    cfg_rts_req = 1; tick(1);
    chk(rts_n, 0, "R1", "rts_n after request");
    cfg_rts_req = 0; tx_busy = 1; tick(3);
    chk(rts_n, 0, "R2", "held while busy");
    tx_busy = 0; tx_pend = 1; tick(2);
    chk(rts_n, 0, "R2", "held while pending");
    tx_pend = 0; tick(1);
    chk(rts_n, 1, "R2", "released when idle");
  endtask

  task automatic t_bus_tx();
    cfg_bus_en = 1; cfg_bus_rts = 2'd0; tick(1);
    chk(rts_n, 1, "R3", "idle bus tx track");
    tx_frame = 1; tick(1);
    chk(rts_n, 1, "R3", "not yet low after one edge");
    tick(1);
    chk(rts_n, 0, "R3", "low after two edges");
    tx_coll = 1; tick(1);
    chk(rts_n, 0, "R3", "collision not yet seen");
    tick(1);
    chk(rts_n, 1, "R3", "high during collision bit");
    tx_coll = 0; tick(2);
    chk(rts_n, 0, "R3", "low after collision");
    tx_frame = 0; tick(2);
    chk(rts_n, 1, "R3", "high after frame");
  endtask

  task automatic t_bus_rx();
    cfg_bus_rts = 2'd1; rx_frame = 1; tick(1);
    chk(rts_n, 0, "R4", "low during receive frame");
    rx_frame = 0; tick(1);
    chk(rts_n, 1, "R4", "high after receive frame");
  endtask

  task automatic t_bus_off();
    cfg_bus_rts = 2'd2; rx_frame = 1; tx_frame = 1; cfg_rts_req = 1; tick(3);
    chk(rts_n, 1, "R5", "mode 2 stays high");
    cfg_bus_rts = 2'd3; tick(2);
    chk(rts_n, 1, "R5", "mode 3 stays high");
    rx_frame = 0; tx_frame = 0; cfg_rts_req = 0; cfg_bus_en = 0; tick(2);
  endtask

  task automatic t_cts();
    chk(tx_en, 0, "R6", "disabled with cts_n high");
    cts_n = 0; tick(2);
    chk(cts_lvl, 0, "R6", "cts_lvl after two edges");
    chk(tx_en, 0, "R6", "tx_en not yet");
    tick(1);
    chk(tx_en, 1, "R6", "enabled with cts_n low");
    cts_n = 1; tick(3);
    chk(tx_en, 0, "R6", "disabled again");
    chk(cts_irq, 0, "R7", "masked changes set nothing");
  endtask

  task automatic t_cts_irq();
    cfg_cts_ie = 1; cts_n = 0; tick(2);
    chk(cts_irq, 0, "R7", "flag not yet");
    tick(1);
    chk(cts_irq, 1, "R7", "flag set");
    tick(5);
    chk(cts_irq, 1, "R11", "flag sticky");
    irq_clr_cts = 1; tick(1); irq_clr_cts = 0;
    chk(cts_irq, 0, "R11", "cleared by pulse");
    cts_n = 1; tick(2); irq_clr_cts = 1; tick(1); irq_clr_cts = 0;
    chk(cts_irq, 1, "R11", "set wins over clear");
    irq_clr_cts = 1; tick(1); irq_clr_cts = 0;
    cfg_cts_ie = 0; tick(1);
  endtask

  task automatic t_cd();
    chk(rx_en, 1, "R8", "enabled without autostart");
    cfg_autostart = 1; tick(1);
    chk(rx_en, 0, "R8", "autostart with cd low");
    cd_in = 1; tick(2);
    chk(cd_lvl, 1, "R8", "cd_lvl after two edges");
    chk(rx_en, 0, "R8", "rx_en not yet");
    tick(1);
    chk(rx_en, 1, "R8", "autostart with cd high");
    cfg_clk_mode = 3'd6; cd_in = 0; tick(3);
    chk(rx_en, 0, "R8", "mode 6 autostart cd low");
    chk(rx_strobe, 0, "R9", "no strobe in mode 6");
    cfg_clk_mode = 3'd1; tick(1);
    chk(rx_en, 1, "R9", "mode 1 receiver enabled");
    cd_in = 1; tick(3);
    chk(rx_strobe, 1, "R9", "strobe follows cd");
    chk(frame_sync, 0, "R9", "no sync in mode 1");
    cfg_clk_mode = 3'd5; tick(1);
    chk(frame_sync, 1, "R9", "sync follows cd");
    chk(rx_strobe, 0, "R9", "no strobe in mode 5");
    cd_in = 0; tick(3);
    chk(frame_sync, 0, "R9", "sync low with cd low");
    chk(cd_irq, 0, "R10", "masked changes set nothing");
  endtask

  task automatic t_cd_irq();
    cfg_cd_ie = 1; cd_in = 1; tick(2);
    chk(cd_irq, 0, "R10", "flag not yet");
    tick(1);
    chk(cd_irq, 1, "R10", "flag set");
    irq_clr_cd = 1; tick(1); irq_clr_cd = 0;
    chk(cd_irq, 0, "R11", "cd flag cleared");
  endtask

  initial begin
    t_reset();
    t_sw_rts();
    t_bus_tx();
    t_bus_rx();
    t_bus_off();
    t_cts();
    t_cts_irq();
    t_cd();
    t_cd_irq();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule